// File: doc/BRIEF.md
# Power-Down and Wake Sequencer

This block decides when a serial transceiver sleeps and when it may be used again. It enters low power in two ways. The first is a hard request: an active-low pin stops everything, including the oscillator. The second is a soft request: both the transmit-enable and receive-enable control bits are clear while the data/command select pin is high. A hard request always wins over a soft one.

On entry to a soft request, a control bit picks one of two wake styles. With the keep-alive style, the oscillator keeps running and the block reports ready on the next cycle after the request clears. With the stop style, the oscillator is stopped and, after wake, ready stays low until a startup counter on the always-on timebase has run a parameterized number of cycles. Leaving a hard request always takes the timed wake.

The block also latches the direction of the shared clock pin. The pin becomes an output if the oscillator is running on the first clock edge after reset is released. It enables the clock doubler when a half-rate input is selected, and it drives two output pins to a programmed level while asleep. Control bits arrive as plain inputs and the block never alters them.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the block is awake: `ready`=1, `pd`=0, `osc_en`=1, `core_clk_en`=1.
- R2: While `hard_n` is low, starting one cycle later, `pd`=1, `osc_en`=0, `core_clk_en`=0 and `ready`=0. This holds whatever the soft inputs are.
- R3: A soft request (`tx_en`=0, `rx_en`=0, `dc_sel`=1, `hard_n`=1) gives `pd`=1 one cycle later. `osc_en` then equals the value of `osc_keep` sampled on that entry cycle.
- R4: When a soft request entered with `osc_keep`=1 clears, `ready` is 1 one cycle later.
- R5: After a hard request ends, or a soft request entered with `osc_keep`=0 clears, `pd` and `ready` stay 0 for exactly `WAIT_CYC` cycles, with `osc_en`=1 and `core_clk_en`=1. `ready` rises on the following cycle.
- R6: A soft request arriving during the startup wait abandons the wait and returns to soft power-down one cycle later.
- R7: While `pd`=1, each pin follows its 2-bit mode: 00 drives 0, 01 drives 1, and 10 or 11 gives `oe`=0 (output value 0). While awake, the pin drives its data input with `oe`=1.
- R8: `clk_pin_out` takes the value of `osc_run` on the first clock edge after `rst_n` rises. It keeps that value until the next reset.
- R9: `clk_pin_oe` is 1 exactly when `clk_pin_out`=1, `clk_out_off`=0 and `osc_en`=1.
- R10: `dbl_en` is 1 exactly when `half_sel`=1 and `pd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_n | input | 1 | Hard power-down request, active low |
| tx_en | input | 1 | Transmit-enable control bit |
| rx_en | input | 1 | Receive-enable control bit |
| dc_sel | input | 1 | Data/command select pin |
| osc_keep | input | 1 | Soft power-down keeps oscillator running when 1 |
| osc_run | input | 1 | Oscillator running indication |
| half_sel | input | 1 | Incoming clock is half rate and needs doubling |
| clk_out_off | input | 1 | Disables driving the clock pin |
| mode_a | input | 2 | Sleep level for pin A |
| mode_b | input | 2 | Sleep level for pin B |
| val_a | input | 1 | Awake data for pin A |
| val_b | input | 1 | Awake data for pin B |
| pd | output | 1 | Block is in power-down |
| ready | output | 1 | Device usable |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| dbl_en | output | 1 | Clock doubler enable |
| clk_pin_out | output | 1 | Clock pin direction, 1 = output |
| clk_pin_oe | output | 1 | Clock pin output enable |
| pin_a | output | 1 | Pin A value |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b | output | 1 | Pin B value |
| pin_b_oe | output | 1 | Pin B output enable |

## Verification
A wrong sequencer state shows at the ports one cycle after the input that caused it. It appears as a mismatch between `pd`, `osc_en` and `ready`, or as pins driven with awake data while asleep. A fault in the startup counter shows only at the end of the wait, as `ready` rising one cycle early or late, so the wait length is counted cycle by cycle. A direction latch that resamples after reset shows as `clk_pin_out` following `osc_run` later in the run.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int WAIT_CYC = 92160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hard_n,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       dc_sel,
  input  logic       osc_keep,
  input  logic       osc_run,
  input  logic       half_sel,
  input  logic       clk_out_off,
  input  logic [1:0] mode_a,
  input  logic [1:0] mode_b,
  input  logic       val_a,
  input  logic       val_b,
  output logic       pd,
  output logic       ready,
  output logic       osc_en,
  output logic       core_clk_en,
  output logic       dbl_en,
  output logic       clk_pin_out,
  output logic       clk_pin_oe,
  output logic       pin_a,
  output logic       pin_a_oe,
  output logic       pin_b,
  output logic       pin_b_oe
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {S_RUN, S_HARD, S_KEEP, S_STOP, S_WAIT} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt;
  logic          armed;

  wire hard_req = !hard_n;
  wire soft_req = !tx_en && !rx_en && dc_sel;
  wire cnt_done = (cnt == CW'(WAIT_CYC - 1));

  always_comb begin
    st_nx = st;
    if (hard_req) st_nx = S_HARD;
    else begin
      case (st)
        S_RUN:  if (soft_req) st_nx = osc_keep ? S_KEEP : S_STOP;
        S_HARD: st_nx = S_WAIT;
        S_KEEP: if (!soft_req) st_nx = S_RUN;
        S_STOP: if (!soft_req) st_nx = S_WAIT;
        S_WAIT: if (soft_req) st_nx = osc_keep ? S_KEEP : S_STOP;
                else if (cnt_done) st_nx = S_RUN;
        default: st_nx = S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st == S_WAIT && st_nx == S_WAIT) ? cnt + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      clk_pin_out <= 1'b0;
    end else if (armed) begin
      armed       <= 1'b0;
      clk_pin_out <= osc_run;
    end
  end

  assign pd          = (st == S_HARD) || (st == S_KEEP) || (st == S_STOP);
  assign ready       = (st == S_RUN);
  assign osc_en      = (st == S_RUN) || (st == S_WAIT) || (st == S_KEEP);
  assign core_clk_en = (st == S_RUN) || (st == S_WAIT);
  assign dbl_en      = half_sel && !pd;
  assign clk_pin_oe  = clk_pin_out && !clk_out_off && osc_en;

  assign pin_a_oe = !pd || !mode_a[1];
  assign pin_a    = pd ? (!mode_a[1] && mode_a[0]) : val_a;
  assign pin_b_oe = !pd || !mode_b[1];
  assign pin_b    = pd ? (!mode_b[1] && mode_b[0]) : val_b;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hard_n,
  input logic tx_en,
  input logic rx_en,
  input logic dc_sel,
  input logic osc_keep,
  input logic pd,
  input logic ready,
  input logic osc_en,
  input logic core_clk_en,
  input logic clk_pin_out
);
  wire soft_req = !tx_en && !rx_en && dc_sel;

  a_r2_hard_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_n |=> (pd && !osc_en && !core_clk_en && !ready));

  a_r3_soft_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_n && soft_req && ready) |=> (pd && (osc_en == $past(osc_keep))));

  a_r4_keep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && osc_en && hard_n && !soft_req) |=> ready);

  a_r5_no_instant_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !ready);

  a_r5_ready_has_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (osc_en && core_clk_en && !pd));

  a_r8_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> $stable(clk_pin_out));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hard_n(hard_n), .tx_en(tx_en), .rx_en(rx_en),
  .dc_sel(dc_sel), .osc_keep(osc_keep), .pd(pd), .ready(ready),
  .osc_en(osc_en), .core_clk_en(core_clk_en), .clk_pin_out(clk_pin_out)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int W = 20;

  logic clk = 0, rst_n = 0;
  logic hard_n = 1, tx_en = 1, rx_en = 1, dc_sel = 0, osc_keep = 0, osc_run = 0;
  logic half_sel = 0, clk_out_off = 0, val_a = 0, val_b = 0;
  logic [1:0] mode_a = 0, mode_b = 0;
  logic pd, ready, osc_en, core_clk_en, dbl_en, clk_pin_out, clk_pin_oe;
  logic pin_a, pin_a_oe, pin_b, pin_b_oe;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.WAIT_CYC(W)) u0 (.*);

  // {tx,rx,dc,keep,mode_a,mode_b,val_a,val_b} -> {pd,osc,pa,paoe,pb,pboe}
  localparam logic [15:0] VEC [6] = '{
    {1'b1,1'b0,1'b1,1'b0,2'b00,2'b01,1'b1,1'b0, 6'b011101},
    {1'b0,1'b0,1'b0,1'b0,2'b00,2'b01,1'b0,1'b1, 6'b010111},
    {1'b0,1'b0,1'b1,1'b1,2'b00,2'b01,1'b1,1'b0, 6'b110111},
    {1'b0,1'b0,1'b1,1'b0,2'b10,2'b11,1'b1,1'b1, 6'b100000},
    {1'b0,1'b0,1'b1,1'b1,2'b01,2'b10,1'b0,1'b1, 6'b111100},
    {1'b0,1'b1,1'b1,1'b0,2'b11,2'b11,1'b1,1'b0, 6'b011101}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wake();
    tx_en = 1; dc_sel = 0; hard_n = 1;
    cyc(W + 3);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(2);
    chk("R1", {ready, pd, osc_en, core_clk_en}, 4'b1011);
    chk("R8 osc off at release", clk_pin_out, 0);
    osc_run = 1; cyc(2);
    chk("R8 held", clk_pin_out, 0);
    rst_n = 0; cyc(1); rst_n = 1; cyc(2);
    chk("R8 osc on at release", clk_pin_out, 1);
    chk("R9 on", clk_pin_oe, 1);
    clk_out_off = 1; cyc(1);
    chk("R9 off bit", clk_pin_oe, 0);
    clk_out_off = 0;

    // R3 R7 table
    foreach (VEC[i]) begin
      wake();
      {tx_en, rx_en, dc_sel, osc_keep, mode_a, mode_b, val_a, val_b} = VEC[i][15:6];
      cyc(2);
      chk($sformatf("R3/R7 vec%0d", i), {pd, osc_en, pin_a, pin_a_oe, pin_b, pin_b_oe}, VEC[i][5:0]);
    end

    // R4 keep wake
    wake();
    tx_en = 0; rx_en = 0; dc_sel = 1; osc_keep = 1; cyc(2);
    tx_en = 1; cyc(1);
    chk("R4", {ready, pd}, 2'b10);

    // R2 priority and R9 in sleep, R10
    wake();
    half_sel = 1; cyc(1);
    chk("R10 awake", dbl_en, 1);
    tx_en = 0; dc_sel = 1; osc_keep = 1; hard_n = 0; cyc(1);
    chk("R2", {pd, osc_en, core_clk_en, ready}, 4'b1000);
    chk("R9 asleep", clk_pin_oe, 0);
    chk("R10 asleep", dbl_en, 0);

    // R5 timed wake from hard
    tx_en = 1; dc_sel = 0; hard_n = 1;
    cyc(W);
    chk("R5 still waiting", {ready, pd, osc_en, core_clk_en}, 4'b0011);
    cyc(1);
    chk("R5 ready", ready, 1);

    // R5 timed wake from soft stop
    tx_en = 0; dc_sel = 1; osc_keep = 0; cyc(2);
    chk("R3 stop", {pd, osc_en}, 2'b10);
    tx_en = 1; cyc(W);
    chk("R5 soft wait", ready, 0);
    cyc(1);
    chk("R5 soft ready", ready, 1);

    // R6 abort
    tx_en = 0; cyc(2);
    tx_en = 1; cyc(3);
    tx_en = 0; osc_keep = 1; cyc(1);
    chk("R6 abort", {pd, osc_en, ready}, 3'b110);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule